// File: doc/BRIEF.md
# Opcode Candidate Matcher

This block identifies which instruction an unknown opcode number could stand for. It examines observations of a small four-register machine. Each observation gives the register file before an instruction, the instruction itself (opcode number plus three operand fields A, B and C), and the register file afterwards.

The block runs sixteen operation models side by side. Each model applies its operation to the "before" state and compares the predicted state with the "after" state. The per-sample result is a 16-bit mask of the operations that fit. The block also keeps two running records. One is a count of observations that three or more operations explain. The other is a 16-by-16 candidate matrix: for each opcode number, it holds the operations that have fit at least once. Software or a later stage reads one row of the matrix at a time by opcode number, and works out the final mapping elsewhere.

The sixteen operations cover addition, multiplication, bitwise AND, bitwise OR, copy, greater-than and equality. Each comes in a register-operand form and an immediate-operand form. Register values are `DW` bits wide and arithmetic wraps at that width.

Top module: `opcode_matcher`

## Requirements
- R1: All sixteen operations are evaluated on each sample. Mask bit k stands for operation k in this order: 0 addr, 1 addi, 2 mulr, 3 muli, 4 banr, 5 bani, 6 borr, 7 bori, 8 setr, 9 seti, 10 gtir, 11 gtri, 12 gtrr, 13 eqir, 14 eqri, 15 eqrr. The letters r and i give the form of A then B: register or immediate. For setr and seti, only the A form applies.
- R2: An operation matches only if the predicted state equals the after state in all four registers. Registers other than C must keep their before values.
- R3: C always names a register. Any operand that an operation reads as a register, including C, must be below 4, or that operation does not match. An operand used as an immediate may take any value.
- R4: Add and multiply results are truncated to DW bits. Greater-than and equal write 1 when true and 0 when false. The copy operations ignore B.
- R5: out_valid goes high exactly one cycle after a cycle with in_valid high. match_mask then shows that sample's result and holds it until the next accepted sample.
- R6: multi_count rises by one, visible one cycle after the sample, for each accepted sample whose mask has three or more bits set. It does not change otherwise.
- R7: multi_count saturates at its all-ones value.
- R8: For an accepted sample with opcode number N, row N of the candidate matrix is ORed with the sample's mask. Rows never lose bits except through clear or reset.
- R9: rd_cands shows row rd_code of the candidate matrix combinationally.
- R10: A cycle with clr high zeroes the count and the whole matrix on the next edge. It overrides any sample in the same cycle, though that sample's mask and out_valid are still produced.
- R11: Synchronous reset zeroes out_valid, match_mask, multi_count and the matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of count and matrix |
| in_valid | input | 1 | Sample present this cycle |
| before_regs | input | 4*DW | Register state before; register i at bits i*DW |
| op_num | input | 4 | Opcode number of the sample |
| fld_a | input | DW | Operand field A |
| fld_b | input | DW | Operand field B |
| fld_c | input | DW | Operand field C (destination) |
| after_regs | input | 4*DW | Register state after; register i at bits i*DW |
| out_valid | output | 1 | Result of the previous cycle's sample |
| match_mask | output | 16 | Operations that fit the sample |
| multi_count | output | CNT_W | Samples with three or more fitting operations |
| rd_code | input | 4 | Opcode number whose matrix row is read |
| rd_cands | output | 16 | Operations seen fitting opcode rd_code |

## Verification
The bench targets these corner cases:
- Out-of-range operand fields: an immediate field above 3 must still match, while the same value in a register field must kill the operation. A design that checked every field, or none, would set or drop the wrong mask bits.
- Sums and products that overflow DW bits: these must wrap. A design that kept a wider result would miss those matches.
- After states that differ only in a register the instruction does not write: no operation may match. A design that compared only register C would report false hits.
- A clear in the same cycle as a sample: the clear must win. A design that let the sample through would leave one count or one matrix bit behind.
- A long run of qualifying samples: the count must stop at its limit. A design without saturation would wrap to zero.

// File: rtl/opm_pkg.sv
package opm_pkg;

    localparam int NUM_OPS = 16;
    localparam int OPC_W   = 4;
    localparam int HITC_W  = $clog2(NUM_OPS + 1);

    typedef enum logic [OPC_W-1:0] {
        OP_ADDR = 4'd0,  OP_ADDI = 4'd1,  OP_MULR = 4'd2,  OP_MULI = 4'd3,
        OP_BANR = 4'd4,  OP_BANI = 4'd5,  OP_BORR = 4'd6,  OP_BORI = 4'd7,
        OP_SETR = 4'd8,  OP_SETI = 4'd9,  OP_GTIR = 4'd10, OP_GTRI = 4'd11,
        OP_GTRR = 4'd12, OP_EQIR = 4'd13, OP_EQRI = 4'd14, OP_EQRR = 4'd15
    } op_kind_e;

    // Which operand fields an operation reads as register indices
    typedef struct packed {
        logic a_is_reg;
        logic b_is_reg;
    } src_form_t;

    typedef logic [NUM_OPS-1:0] op_mask_t;

    function automatic src_form_t form_of(op_kind_e k);
        src_form_t f;
        case (k)
            OP_ADDR, OP_MULR, OP_BANR, OP_BORR, OP_GTRR, OP_EQRR: f = '{a_is_reg: 1'b1, b_is_reg: 1'b1};
            OP_ADDI, OP_MULI, OP_BANI, OP_BORI, OP_GTRI, OP_EQRI, OP_SETR: f = '{a_is_reg: 1'b1, b_is_reg: 1'b0};
            OP_GTIR, OP_EQIR: f = '{a_is_reg: 1'b0, b_is_reg: 1'b1};
            default: f = '{a_is_reg: 1'b0, b_is_reg: 1'b0};
        endcase
        return f;
    endfunction

    function automatic logic [HITC_W-1:0] count_hits(op_mask_t m);
        logic [HITC_W-1:0] n;
        n = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            n = n + HITC_W'(m[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/opm_eval.sv
module opm_eval
    import opm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int OP   = 0
) (
    input  logic [NREG*DW-1:0] before_regs,
    input  logic [DW-1:0]      fld_a,
    input  logic [DW-1:0]      fld_b,
    input  logic [DW-1:0]      fld_c,
    input  logic [NREG*DW-1:0] after_regs,
    output logic               hit
);
    localparam op_kind_e        KIND   = op_kind_e'(OP);
    localparam src_form_t       FORM   = form_of(KIND);
    localparam int              IW     = $clog2(NREG);
    localparam logic [DW-1:0]   NREG_W = DW'(NREG);

    logic [DW-1:0] bef [NREG];
    logic [DW-1:0] aft [NREG];
    logic [NREG-1:0] reg_same;

    logic a_ok, b_ok, c_ok, operands_ok;
    logic [IW-1:0] a_idx, b_idx, c_idx;
    logic [DW-1:0] opx, opy, result;

    assign a_ok  = fld_a < NREG_W;
    assign b_ok  = fld_b < NREG_W;
    assign c_ok  = fld_c < NREG_W;
    assign a_idx = fld_a[IW-1:0];
    assign b_idx = fld_b[IW-1:0];
    assign c_idx = fld_c[IW-1:0];

    assign operands_ok = c_ok && (!FORM.a_is_reg || a_ok) && (!FORM.b_is_reg || b_ok);

    assign opx = FORM.a_is_reg ? bef[a_idx] : fld_a;
    assign opy = FORM.b_is_reg ? bef[b_idx] : fld_b;

    always_comb begin
        case (KIND)
            OP_ADDR, OP_ADDI: result = opx + opy;
            OP_MULR, OP_MULI: result = opx * opy;
            OP_BANR, OP_BANI: result = opx & opy;
            OP_BORR, OP_BORI: result = opx | opy;
            OP_SETR, OP_SETI: result = opx;
            OP_GTIR, OP_GTRI, OP_GTRR: result = {{(DW-1){1'b0}}, opx > opy};
            default: result = {{(DW-1){1'b0}}, opx == opy};
        endcase
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign bef[i] = before_regs[i*DW +: DW];
        assign aft[i] = after_regs[i*DW +: DW];
        assign reg_same[i] = (c_idx == IW'(i)) ? (aft[i] == result) : (aft[i] == bef[i]);
    end

    assign hit = operands_ok && (&reg_same);

endmodule

// File: rtl/opm_tally.sv
module opm_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             fire,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (fire && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(clr) |->
            (count == $past(count)) || (count == $past(count) + 1'b1));

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(clr) && $past(count) == CNT_MAX |-> count == CNT_MAX);

    // R10
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

endmodule

// File: rtl/opm_cand_matrix.sv
module opm_cand_matrix
    import opm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [OPC_W-1:0] wr_code,
    input  op_mask_t         wr_ops,
    input  logic [OPC_W-1:0] rd_code,
    output op_mask_t         rd_ops
);
    op_mask_t rows [NUM_OPS];

    for (genvar r = 0; r < NUM_OPS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                rows[r] <= '0;
            end else if (wr_en && wr_code == OPC_W'(r)) begin
                rows[r] <= rows[r] | wr_ops;
            end
        end

        // R8
        row_grow_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && !$past(clr) |-> (rows[r] & $past(rows[r])) == $past(rows[r]));
    end

    assign rd_ops = rows[rd_code];

endmodule

// File: rtl/opcode_matcher.sv
module opcode_matcher
    import opm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic [4*DW-1:0]      before_regs,
    input  logic [OPC_W-1:0]     op_num,
    input  logic [DW-1:0]        fld_a,
    input  logic [DW-1:0]        fld_b,
    input  logic [DW-1:0]        fld_c,
    input  logic [4*DW-1:0]      after_regs,
    output logic                 out_valid,
    output logic [NUM_OPS-1:0]   match_mask,
    output logic [CNT_W-1:0]     multi_count,
    input  logic [OPC_W-1:0]     rd_code,
    output logic [NUM_OPS-1:0]   rd_cands
);
    localparam int            NREG   = 4;
    localparam int            MULTI  = 3;
    localparam logic [DW-1:0] NREG_W = DW'(NREG);

    op_mask_t hit_vec;
    logic     is_multi;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        opm_eval #(.DW(DW), .NREG(NREG), .OP(k)) u_eval (
            .before_regs (before_regs),
            .fld_a       (fld_a),
            .fld_b       (fld_b),
            .fld_c       (fld_c),
            .after_regs  (after_regs),
            .hit         (hit_vec[k])
        );
    end

    assign is_multi = count_hits(hit_vec) >= HITC_W'(MULTI);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            match_mask <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                match_mask <= hit_vec;
            end
        end
    end

    opm_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .fire  (in_valid && is_multi),
        .count (multi_count)
    );

    opm_cand_matrix u_matrix (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .wr_en   (in_valid),
        .wr_code (op_num),
        .wr_ops  (hit_vec),
        .rd_code (rd_code),
        .rd_ops  (rd_cands)
    );

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(match_mask));

    // R3
    c_range_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (fld_c >= NREG_W) |=> match_mask == '0);

    // R6
    cnt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(clr) && multi_count != $past(multi_count) |->
            out_valid && $countones(match_mask) >= MULTI);

endmodule

// File: tb/opcode_matcher_bench.sv
`timescale 1ns/1ps
module opcode_matcher_bench;
    localparam int DW    = 16;
    localparam int CNT_W = 5;
    typedef logic [3:0][DW-1:0] rf_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    rf_t  before_regs = '0;
    rf_t  after_regs  = '0;
    logic [3:0]    op_num = '0;
    logic [DW-1:0] fld_a = '0, fld_b = '0, fld_c = '0;
    logic          out_valid;
    logic [15:0]   match_mask;
    logic [CNT_W-1:0] multi_count;
    logic [3:0]    rd_code = '0;
    logic [15:0]   rd_cands;

    int n_chk = 0;
    int n_bad = 0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic [15:0]      m_rows [16];

    always #2 clk = ~clk;

    opcode_matcher #(.DW(DW), .CNT_W(CNT_W)) u_opcode_matcher (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .before_regs(before_regs), .op_num(op_num),
        .fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c),
        .after_regs(after_regs), .out_valid(out_valid),
        .match_mask(match_mask), .multi_count(multi_count),
        .rd_code(rd_code), .rd_cands(rd_cands)
    );

    function automatic rf_t mk(input int r0, input int r1, input int r2, input int r3);
        rf_t x;
        x[0] = DW'(r0); x[1] = DW'(r1); x[2] = DW'(r2); x[3] = DW'(r3);
        return x;
    endfunction

    // Independent model of the requirements R1-R4 (operation k -> bit k)
    function automatic logic [15:0] model_mask(input rf_t bf, input logic [DW-1:0] a,
                                               input logic [DW-1:0] b, input logic [DW-1:0] c,
                                               input rf_t af);
        logic [15:0] m;
        m = '0;
        for (int k = 0; k < 16; k++) begin
            logic need_a, need_b, ok;
            logic [DW-1:0] ra, rb, res;
            rf_t pr;
            need_a = !(k == 9 || k == 10 || k == 13);
            need_b = (k == 0 || k == 2 || k == 4 || k == 6 || k == 10 || k == 12 || k == 13 || k == 15);
            ra = (a < 4) ? bf[a[1:0]] : '0;
            rb = (b < 4) ? bf[b[1:0]] : '0;
            case (k)
                0:  res = ra + rb;
                1:  res = ra + b;
                2:  res = DW'(ra * rb);
                3:  res = DW'(ra * b);
                4:  res = ra & rb;
                5:  res = ra & b;
                6:  res = ra | rb;
                7:  res = ra | b;
                8:  res = ra;
                9:  res = a;
                10: res = (a > rb) ? 1 : 0;
                11: res = (ra > b) ? 1 : 0;
                12: res = (ra > rb) ? 1 : 0;
                13: res = (a == rb) ? 1 : 0;
                14: res = (ra == b) ? 1 : 0;
                default: res = (ra == rb) ? 1 : 0;
            endcase
            ok = (c < 4) && (!need_a || a < 4) && (!need_b || b < 4);
            pr = bf;
            pr[c[1:0]] = res;
            m[k] = ok && (pr == af);
        end
        return m;
    endfunction

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_accept(input logic [15:0] m, input logic [3:0] opc, input bit with_clr);
        int n;
        n = $countones(m);
        if (with_clr) begin
            m_cnt = '0;
            for (int r = 0; r < 16; r++) m_rows[r] = '0;
        end else begin
            if (n >= 3 && m_cnt != '1) m_cnt = m_cnt + 1'b1;
            m_rows[opc] = m_rows[opc] | m;
        end
    endtask

    task automatic drive(input rf_t bf, input logic [3:0] opc, input int a, input int b,
                         input int c, input rf_t af);
        in_valid    = 1'b1;
        before_regs = bf;
        after_regs  = af;
        op_num      = opc;
        fld_a = DW'(a); fld_b = DW'(b); fld_c = DW'(c);
    endtask

    task automatic check_rows(input string req);
        for (int r = 0; r < 16; r++) begin
            rd_code = 4'(r);
            #0.1;
            chk(rd_cands == m_rows[r], req, $sformatf("row %0d", r), rd_cands, m_rows[r]);
        end
    endtask

    // One sample, checked at the negedge after the accepting edge
    task automatic one_sample(input string req, input rf_t bf, input logic [3:0] opc,
                              input int a, input int b, input int c, input rf_t af);
        logic [15:0] em;
        @(negedge clk);
        drive(bf, opc, a, b, c, af);
        em = model_mask(bf, DW'(a), DW'(b), DW'(c), af);
        @(negedge clk);
        in_valid = 1'b0;
        model_accept(em, opc, 1'b0);
        chk(out_valid == 1'b1, "R5", "out_valid", out_valid, 1);
        chk(match_mask == em, req, "mask", match_mask, em);
        chk(multi_count == m_cnt, "R6", "count", multi_count, m_cnt);
        rd_code = opc;
        #0.1;
        chk(rd_cands == m_rows[opc], "R9", "row read", rd_cands, m_rows[opc]);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid", out_valid, 0);
        chk(match_mask == '0, "R11", "mask", match_mask, 0);
        chk(multi_count == '0, "R11", "count", multi_count, 0);
        rst = 1'b0;
        check_rows("R11");
    endtask

    task automatic t_known();
        // mulr, addi, seti fit: bits 1,2,9
        one_sample("R1", mk(3, 2, 1, 1), 4'd9, 2, 1, 2, mk(3, 2, 2, 1));
        chk(match_mask == 16'h0206, "R1", "known mask", match_mask, 16'h0206);
        chk(multi_count == 1, "R6", "known count", multi_count, 1);
    endtask

    task automatic t_range();
        one_sample("R3", mk(1, 2, 3, 4), 4'd2, 1, 2, 4, mk(1, 2, 3, 4));
        chk(match_mask == '0, "R3", "C out of range", match_mask, 0);
        // immediate A=7 accepted by seti only
        one_sample("R3", mk(0, 0, 0, 0), 4'd3, 7, 0, 0, mk(7, 0, 0, 0));
        chk(match_mask == 16'h0200, "R3", "imm A=7", match_mask, 16'h0200);
        // B=9 as register kills banr, immediate bani passes
        one_sample("R3", mk(6, 5, 4, 3), 4'd4, 0, 9, 1, mk(6, 0, 4, 3));
    endtask

    task automatic t_width();
        one_sample("R4", mk(16'hFFFF, 1, 5, 5), 4'd5, 0, 1, 2, mk(16'hFFFF, 1, 0, 5));
        chk(match_mask[0] == 1'b1, "R4", "addr wrap", match_mask[0], 1);
        one_sample("R4", mk(16'h8000, 2, 0, 0), 4'd6, 0, 2, 3, mk(16'h8000, 2, 0, 0));
        one_sample("R4", mk(5, 5, 0, 9), 4'd7, 0, 1, 3, mk(5, 5, 0, 1));
        one_sample("R4", mk(9, 3, 0, 0), 4'd8, 0, 1234, 2, mk(9, 3, 9, 0));
        chk(match_mask[8] == 1'b1, "R4", "setr ignores B", match_mask[8], 1);
    endtask

    task automatic t_untouched();
        one_sample("R2", mk(3, 2, 1, 1), 4'd10, 2, 1, 2, mk(3, 2, 2, 7));
        chk(match_mask == '0, "R2", "stray reg diff", match_mask, 0);
    endtask

    task automatic t_stream();
        logic [15:0] em [4];
        rf_t bfs [4];
        rf_t afs [4];
        bfs[0] = mk(1, 1, 1, 1); afs[0] = mk(1, 1, 1, 1);
        bfs[1] = mk(2, 3, 4, 5); afs[1] = mk(2, 3, 4, 6);
        bfs[2] = mk(0, 4, 4, 0); afs[2] = mk(1, 4, 4, 0);
        bfs[3] = mk(7, 7, 7, 7); afs[3] = mk(7, 7, 14, 7);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i > 0) begin
                model_accept(em[i-1], 4'd12, 1'b0);
                chk(out_valid == 1'b1, "R5", "stream valid", out_valid, 1);
                chk(match_mask == em[i-1], "R5", $sformatf("stream mask %0d", i-1), match_mask, em[i-1]);
                chk(multi_count == m_cnt, "R6", "stream count", multi_count, m_cnt);
            end
            if (i < 4) begin
                drive(bfs[i], 4'd12, 1, 2, (i == 0) ? 0 : (i == 3 ? 2 : (i == 1 ? 3 : 0)), afs[i]);
                em[i] = model_mask(bfs[i], fld_a, fld_b, fld_c, afs[i]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", "idle valid", out_valid, 0);
        chk(match_mask == em[3], "R5", "mask held", match_mask, em[3]);
        check_rows("R8");
    endtask

    task automatic t_accumulate();
        one_sample("R8", mk(3, 2, 1, 1), 4'd9, 2, 1, 2, mk(3, 2, 2, 1));
        one_sample("R8", mk(0, 0, 0, 0), 4'd9, 5, 0, 1, mk(0, 5, 0, 0));
        rd_code = 4'd9;
        #0.1;
        chk(rd_cands == 16'h0206, "R8", "row 9 kept old bits", rd_cands, 16'h0206);
        chk(rd_cands == m_rows[9], "R8", "row 9", rd_cands, m_rows[9]);
        rd_code = 4'd15;
        #0.1;
        chk(rd_cands == '0, "R9", "unseen row", rd_cands, 0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        drive(mk(3, 2, 1, 1), 4'd1, 2, 1, 2, mk(3, 2, 2, 1));
        clr = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        clr = 1'b0;
        model_accept(16'h0206, 4'd1, 1'b1);
        chk(out_valid == 1'b1, "R10", "valid with clr", out_valid, 1);
        chk(match_mask == 16'h0206, "R10", "mask with clr", match_mask, 16'h0206);
        chk(multi_count == '0, "R10", "count cleared", multi_count, 0);
        check_rows("R10");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 35; i++) begin
            one_sample("R7", mk(3, 2, 1, 1), 4'd0, 2, 1, 2, mk(3, 2, 2, 1));
        end
        chk(multi_count == 5'h1F, "R7", "saturated", multi_count, 31);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cnt = '0;
        for (int r = 0; r < 16; r++) m_rows[r] = '0;
        chk(multi_count == '0, "R11", "count after rst", multi_count, 0);
        chk(out_valid == 1'b0, "R11", "valid after rst", out_valid, 0);
        chk(match_mask == '0, "R11", "mask after rst", match_mask, 0);
        check_rows("R11");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int r = 0; r < 16; r++) m_rows[r] = '0;
        t_reset();
        t_known();
        t_range();
        t_width();
        t_untouched();
        t_stream();
        t_accumulate();
        t_clear();
        t_saturate();
        t_reset_again();
        finish_run();
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

endmodule